// File: doc/BRIEF.md
# Register Consumer Tracking Table

This block tells the decode stage of a pointer-chasing out-of-order core where each source operand will come from. It holds one entry per architectural register. An entry is either null, meaning the committed value sits in the architected register file, or a reference to the newest in-flight use of that register. A reference is a queue entry index plus a slot tag: first source, second source or destination. A decoding instruction looks up its sources. A null entry means the operand is read from the register file at dispatch. A live entry produces a link request, so that the earlier reference's next-use pointer can be pointed at the new instruction's source slot. The table is then rewritten so that later readers chain onto this instruction, and the destination register is redirected to its destination slot.

Branches take a snapshot of the whole table, including the per-entry valid bits. A misprediction restores that snapshot and frees it together with every younger snapshot. A correctly predicted branch only frees its snapshot. Commits reset an entry to null when that entry still names the committing instruction. The same clear is applied inside every held snapshot, so a restore never brings back a pointer to a retired instruction. Decode stalls when a branch finds no free snapshot slot, and it also stalls during a restore.

Top module: `rct_table`

## Requirements
- R1: After reset every entry is null: an enabled source lookup reports a register-file read and raises no link request.
- R2: An enabled source whose entry is live raises a link request carrying the stored queue index and slot (slot codes: first source = 0, second source = 1, destination = 2) and does not request a register-file read; a null entry requests a register-file read and no link.
- R3: An accepted decode rewrites each enabled source register's entry to the new queue index with that source's slot. When both sources name the same register, the second source links to the new instruction's own first-source slot and the entry ends on the second-source slot.
- R4: An accepted decode rewrites the destination register's entry to the new index with the destination slot, and this update takes precedence over the source updates of the same instruction.
- R5: An accepted branch takes the lowest-numbered free snapshot slot, reports that number on `dec_ckpt_id`, and the snapshot includes the branch's own table updates.
- R6: A commit resets its register's entry to null only when the entry's queue index equals the committing index; otherwise the entry is unchanged.
- R7: When a decode and a commit touch the same register in one cycle, the decode's update is kept.
- R8: A branch presented while every snapshot slot is held raises `dec_stall` and is not accepted.
- R9: A misprediction restores the table from the named snapshot, frees that slot and all slots taken after it, and holds `dec_stall` high in that cycle so that the decode is dropped.
- R10: A commit applies its null-clear to the matching entries of every held snapshot as well.
- R11: A correctly predicted branch frees its snapshot slot for reuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_qidx | input | QIDX_W | Queue index assigned to the decoding instruction |
| dec_s1_en | input | 1 | First source is a register |
| dec_s1_reg | input | RW | First source register |
| dec_s2_en | input | 1 | Second source is a register |
| dec_s2_reg | input | RW | Second source register |
| dec_d_en | input | 1 | Instruction writes a register |
| dec_d_reg | input | RW | Destination register |
| dec_branch | input | 1 | Instruction is a predicted branch needing a snapshot |
| dec_stall | output | 1 | Decode is not accepted this cycle |
| dec_ckpt_id | output | CW | Snapshot slot granted to the branch |
| s1_use_arf | output | 1 | First source is read from the register file |
| s1_link | output | 1 | Link request for the first source |
| s1_link_idx | output | QIDX_W | Queue index of the earlier reference |
| s1_link_slot | output | 2 | Slot of the earlier reference |
| s2_use_arf | output | 1 | Second source is read from the register file |
| s2_link | output | 1 | Link request for the second source |
| s2_link_idx | output | QIDX_W | Queue index of the earlier reference |
| s2_link_slot | output | 2 | Slot of the earlier reference |
| cmt_valid | input | 1 | An instruction commits |
| cmt_reg | input | RW | Destination register of the committing instruction |
| cmt_qidx | input | QIDX_W | Queue index of the committing instruction |
| br_ok_valid | input | 1 | A branch resolved as correctly predicted |
| br_ok_id | input | CW | Its snapshot slot |
| br_bad_valid | input | 1 | A branch resolved as mispredicted |
| br_bad_id | input | CW | Its snapshot slot |

## Verification
Lookup results, link requests, `dec_stall` and `dec_ckpt_id` are combinational: they are due in the same cycle the decode inputs are presented. The bench therefore drives those inputs just after a falling edge and samples two time units later, before the next rising edge. Table rewrites, commit clears, restores and snapshot releases are registered, so they become visible only through a lookup one cycle after the stimulus. The bench reads them back with a non-updating probe in the following cycle. Each directed test places its stimulus on one edge and its probe in the next cycle, so no result is read before the register that produces it has loaded.

// File: rtl/rct_pkg.sv
package rct_pkg;

    // Slot tag of a reference held in the table
    typedef enum logic [1:0] {
        SLOT_S1 = 2'd0,
        SLOT_S2 = 2'd1,
        SLOT_D  = 2'd2
    } slot_e;

    // Width of a clog2-sized index that never collapses to zero
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rct_src_port.sv
module rct_src_port
    import rct_pkg::*;
#(
    parameter int QIDX_W = 5
) (
    input  logic              en,
    input  logic [QIDX_W+2:0] entry,
    input  logic              fwd,
    input  logic [QIDX_W-1:0] fwd_idx,
    output logic              use_arf,
    output logic              link,
    output logic [QIDX_W-1:0] link_idx,
    output logic [1:0]        link_slot
);
    typedef struct packed {
        logic              vld;
        slot_e             slot;
        logic [QIDX_W-1:0] idx;
    } ref_t;

    ref_t eff;

    // A same-instruction forward points at the new instruction's first source
    always_comb begin
        if (fwd) begin
            eff.vld  = 1'b1;
            eff.slot = SLOT_S1;
            eff.idx  = fwd_idx;
        end else begin
            eff = ref_t'(entry);
        end
    end

    assign link      = en & eff.vld;
    assign use_arf   = en & ~eff.vld;
    assign link_idx  = eff.idx;
    assign link_slot = eff.slot;

endmodule

// File: rtl/rct_ckpt_alloc.sv
module rct_ckpt_alloc
    import rct_pkg::*;
#(
    parameter  int NUM_CKPT = 2,
    localparam int CW       = idx_width(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          ok_valid,
    input  logic [CW-1:0] ok_id,
    input  logic          bad_valid,
    input  logic [CW-1:0] bad_id,
    output logic          full,
    output logic [CW-1:0] gnt_id
);
    logic [NUM_CKPT-1:0] busy_q, busy_d;
    // yng_q[j][k] set: slot k was taken while slot j was held
    logic [NUM_CKPT-1:0] yng_q [NUM_CKPT];

    assign full = &busy_q;

    always_comb begin
        gnt_id = '0;
        for (int k = NUM_CKPT - 1; k >= 0; k--) begin
            if (!busy_q[k]) gnt_id = CW'(k);
        end
    end

    always_comb begin
        busy_d = busy_q;
        if (ok_valid) busy_d[ok_id] = 1'b0;
        if (bad_valid) begin
            busy_d         = busy_d & ~yng_q[bad_id];
            busy_d[bad_id] = 1'b0;
        end
        if (take) busy_d[gnt_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int j = 0; j < NUM_CKPT; j++) yng_q[j] <= '0;
        end else begin
            busy_q <= busy_d;
            if (take) begin
                for (int j = 0; j < NUM_CKPT; j++) begin
                    if (CW'(j) == gnt_id) yng_q[j] <= '0;
                    else                  yng_q[j][gnt_id] <= busy_q[j];
                end
            end
        end
    end

    // R5: a grant never lands on a held slot
    always @(posedge clk) begin
        if (!rst && take) begin
            a_r5_grant_free: assert (!busy_q[gnt_id])
                else $error("snapshot grant on held slot");
        end
    end

    // R5: a granted slot is held in the next cycle
    a_r5_grant_held: assert property (@(posedge clk) disable iff (rst)
        take |=> busy_q[$past(gnt_id)]);

    // R11: a correct prediction releases its slot
    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        (ok_valid && !(take && gnt_id == ok_id)) |=> !busy_q[$past(ok_id)]);

    // R9: a misprediction releases its slot
    a_r9_bad_release: assert property (@(posedge clk) disable iff (rst)
        (bad_valid && !take) |=> !busy_q[$past(bad_id)]);

endmodule

// File: rtl/rct_table.sv
module rct_table
    import rct_pkg::*;
#(
    parameter  int NUM_REGS = 8,
    parameter  int QIDX_W   = 5,
    parameter  int NUM_CKPT = 2,
    localparam int RW       = idx_width(NUM_REGS),
    localparam int CW       = idx_width(NUM_CKPT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [QIDX_W-1:0] dec_qidx,
    input  logic              dec_s1_en,
    input  logic [RW-1:0]     dec_s1_reg,
    input  logic              dec_s2_en,
    input  logic [RW-1:0]     dec_s2_reg,
    input  logic              dec_d_en,
    input  logic [RW-1:0]     dec_d_reg,
    input  logic              dec_branch,
    output logic              dec_stall,
    output logic [CW-1:0]     dec_ckpt_id,
    output logic              s1_use_arf,
    output logic              s1_link,
    output logic [QIDX_W-1:0] s1_link_idx,
    output logic [1:0]        s1_link_slot,
    output logic              s2_use_arf,
    output logic              s2_link,
    output logic [QIDX_W-1:0] s2_link_idx,
    output logic [1:0]        s2_link_slot,
    input  logic              cmt_valid,
    input  logic [RW-1:0]     cmt_reg,
    input  logic [QIDX_W-1:0] cmt_qidx,
    input  logic              br_ok_valid,
    input  logic [CW-1:0]     br_ok_id,
    input  logic              br_bad_valid,
    input  logic [CW-1:0]     br_bad_id
);
    typedef struct packed {
        logic              vld;
        slot_e             slot;
        logic [QIDX_W-1:0] idx;
    } ref_t;

    ref_t tbl_q  [NUM_REGS];
    ref_t tbl_d  [NUM_REGS];
    ref_t snap_q [NUM_CKPT][NUM_REGS];

    logic          full;
    logic [CW-1:0] gnt_id;
    logic          acc, take_ckpt, s2_fwd, dec_touch_cmt;

    assign dec_stall   = br_bad_valid | (dec_branch & full);
    assign acc         = dec_valid & ~dec_stall;
    assign take_ckpt   = acc & dec_branch;
    assign dec_ckpt_id = gnt_id;
    assign s2_fwd      = dec_s1_en & dec_s2_en & (dec_s2_reg == dec_s1_reg);

    assign dec_touch_cmt = acc & ((dec_s1_en & (dec_s1_reg == cmt_reg)) |
                                  (dec_s2_en & (dec_s2_reg == cmt_reg)) |
                                  (dec_d_en  & (dec_d_reg  == cmt_reg)));

    rct_src_port #(.QIDX_W(QIDX_W)) u_port_a (
        .en        (dec_s1_en),
        .entry     (tbl_q[dec_s1_reg]),
        .fwd       (1'b0),
        .fwd_idx   (dec_qidx),
        .use_arf   (s1_use_arf),
        .link      (s1_link),
        .link_idx  (s1_link_idx),
        .link_slot (s1_link_slot)
    );

    rct_src_port #(.QIDX_W(QIDX_W)) u_port_b (
        .en        (dec_s2_en),
        .entry     (tbl_q[dec_s2_reg]),
        .fwd       (s2_fwd),
        .fwd_idx   (dec_qidx),
        .use_arf   (s2_use_arf),
        .link      (s2_link),
        .link_idx  (s2_link_idx),
        .link_slot (s2_link_slot)
    );

    rct_ckpt_alloc #(.NUM_CKPT(NUM_CKPT)) u_alloc (
        .clk       (clk),
        .rst       (rst),
        .take      (take_ckpt),
        .ok_valid  (br_ok_valid),
        .ok_id     (br_ok_id),
        .bad_valid (br_bad_valid),
        .bad_id    (br_bad_id),
        .full      (full),
        .gnt_id    (gnt_id)
    );

    // Next table: restore, then commit clear, then decode (S1, S2, D in order)
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++)
            tbl_d[r] = br_bad_valid ? snap_q[br_bad_id][r] : tbl_q[r];
        if (cmt_valid && tbl_d[cmt_reg].vld && tbl_d[cmt_reg].idx == cmt_qidx)
            tbl_d[cmt_reg] = '0;
        if (acc) begin
            if (dec_s1_en) begin
                tbl_d[dec_s1_reg].vld  = 1'b1;
                tbl_d[dec_s1_reg].slot = SLOT_S1;
                tbl_d[dec_s1_reg].idx  = dec_qidx;
            end
            if (dec_s2_en) begin
                tbl_d[dec_s2_reg].vld  = 1'b1;
                tbl_d[dec_s2_reg].slot = SLOT_S2;
                tbl_d[dec_s2_reg].idx  = dec_qidx;
            end
            if (dec_d_en) begin
                tbl_d[dec_d_reg].vld  = 1'b1;
                tbl_d[dec_d_reg].slot = SLOT_D;
                tbl_d[dec_d_reg].idx  = dec_qidx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REGS; r++) tbl_q[r] <= '0;
            for (int c = 0; c < NUM_CKPT; c++)
                for (int r = 0; r < NUM_REGS; r++) snap_q[c][r] <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) tbl_q[r] <= tbl_d[r];
            for (int c = 0; c < NUM_CKPT; c++) begin
                for (int r = 0; r < NUM_REGS; r++) begin
                    if (take_ckpt && gnt_id == CW'(c))
                        snap_q[c][r] <= tbl_d[r];
                    else if (cmt_valid && cmt_reg == RW'(r) &&
                             snap_q[c][r].vld && snap_q[c][r].idx == cmt_qidx)
                        snap_q[c][r] <= '0;
                end
            end
        end
    end

    // R4: an accepted destination lands on its D slot
    a_r4_dst_redirect: assert property (@(posedge clk) disable iff (rst)
        (acc && dec_d_en) |=>
            (tbl_q[$past(dec_d_reg)].vld &&
             tbl_q[$past(dec_d_reg)].slot == SLOT_D &&
             tbl_q[$past(dec_d_reg)].idx == $past(dec_qidx)));

    // R9: a restore blocks decode in its cycle
    a_r9_restore_stall: assert property (@(posedge clk) disable iff (rst)
        br_bad_valid |-> dec_stall);

    // R6: a matching commit with no competing update leaves the entry null
    a_r6_commit_null: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && !br_bad_valid && !dec_touch_cmt &&
         tbl_q[cmt_reg].vld && tbl_q[cmt_reg].idx == cmt_qidx)
            |=> !tbl_q[$past(cmt_reg)].vld);

    // R2: a lookup never asks for both a link and a register-file read
    a_r2_one_source: assert property (@(posedge clk) disable iff (rst)
        !(s1_link && s1_use_arf) && !(s2_link && s2_use_arf));

endmodule

// File: tb/sim_rct_table.sv
module sim_rct_table;
    localparam int CLK_T = 10;
    localparam int NR = 8, QW = 5, NC = 2, RW = 3, CW = 1;

    logic clk = 1'b0, rst = 1'b1;
    logic dec_valid, dec_s1_en, dec_s2_en, dec_d_en, dec_branch;
    logic [QW-1:0] dec_qidx;
    logic [RW-1:0] dec_s1_reg, dec_s2_reg, dec_d_reg;
    logic dec_stall;
    logic [CW-1:0] dec_ckpt_id;
    logic s1_use_arf, s1_link, s2_use_arf, s2_link;
    logic [QW-1:0] s1_link_idx, s2_link_idx;
    logic [1:0] s1_link_slot, s2_link_slot;
    logic cmt_valid;
    logic [RW-1:0] cmt_reg;
    logic [QW-1:0] cmt_qidx;
    logic br_ok_valid, br_bad_valid;
    logic [CW-1:0] br_ok_id, br_bad_id;

    int total = 0, bad = 0;

    rct_table #(.NUM_REGS(NR), .QIDX_W(QW), .NUM_CKPT(NC)) u0 (.*);

    always #(CLK_T/2) clk = ~clk;

    typedef struct packed {
        logic [4:0] q;
        logic a_en; logic [2:0] a_r;
        logic b_en; logic [2:0] b_r;
        logic d_en; logic [2:0] d_r;
        logic xa_arf; logic xa_lk; logic [4:0] xa_i; logic [1:0] xa_s;
        logic xb_arf; logic xb_lk; logic [4:0] xb_i; logic [1:0] xb_s;
    } vec_t;

    // slot codes: 0 first source, 1 second source, 2 destination
    localparam vec_t VEC [8] = '{
        '{5'd1, 1'b1,3'd4, 1'b0,3'd0, 1'b1,3'd1, 1'b1,1'b0,5'd0,2'd0, 1'b0,1'b0,5'd0,2'd0},
        '{5'd2, 1'b1,3'd1, 1'b1,3'd3, 1'b1,3'd3, 1'b0,1'b1,5'd1,2'd2, 1'b1,1'b0,5'd0,2'd0},
        '{5'd3, 1'b1,3'd4, 1'b0,3'd0, 1'b1,3'd4, 1'b0,1'b1,5'd1,2'd0, 1'b0,1'b0,5'd0,2'd0},
        '{5'd4, 1'b1,3'd3, 1'b1,3'd5, 1'b0,3'd0, 1'b0,1'b1,5'd2,2'd2, 1'b1,1'b0,5'd0,2'd0},
        '{5'd5, 1'b1,3'd4, 1'b1,3'd5, 1'b0,3'd0, 1'b0,1'b1,5'd3,2'd2, 1'b0,1'b1,5'd4,2'd1},
        '{5'd6, 1'b1,3'd2, 1'b1,3'd2, 1'b1,3'd2, 1'b1,1'b0,5'd0,2'd0, 1'b0,1'b1,5'd6,2'd0},
        '{5'd7, 1'b1,3'd2, 1'b1,3'd1, 1'b1,3'd0, 1'b0,1'b1,5'd6,2'd2, 1'b0,1'b1,5'd2,2'd0},
        '{5'd8, 1'b1,3'd0, 1'b1,3'd3, 1'b0,3'd0, 1'b0,1'b1,5'd7,2'd2, 1'b0,1'b1,5'd4,2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        dec_valid = 0; dec_qidx = '0; dec_branch = 0;
        dec_s1_en = 0; dec_s1_reg = '0; dec_s2_en = 0; dec_s2_reg = '0;
        dec_d_en = 0; dec_d_reg = '0;
        cmt_valid = 0; cmt_reg = '0; cmt_qidx = '0;
        br_ok_valid = 0; br_ok_id = '0; br_bad_valid = 0; br_bad_id = '0;
    endtask

    // Non-updating lookup of one register through the first source port
    task automatic probe(input int r, input int x_arf, input int x_lk,
                         input int x_i, input int x_s, input string tag);
        idle();
        dec_s1_en = 1; dec_s1_reg = RW'(r);
        #2;
        chk({tag, " arf"}, s1_use_arf, x_arf);
        chk({tag, " link"}, s1_link, x_lk);
        if (x_lk != 0) begin
            chk({tag, " idx"}, s1_link_idx, x_i);
            chk({tag, " slot"}, s1_link_slot, x_s);
        end
        @(negedge clk);
    endtask

    task automatic branch(input int q, input int x_id, input string tag);
        idle();
        dec_valid = 1; dec_branch = 1; dec_qidx = QW'(q);
        #2;
        chk({tag, " stall"}, dec_stall, 0);
        chk({tag, " id"}, dec_ckpt_id, x_id);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_T * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: all entries null after reset
        for (int r = 0; r < NR; r++) probe(r, 1, 0, 0, 0, "R1 reset");

        // R2 R3 R4: vector walk
        foreach (VEC[i]) begin
            idle();
            dec_valid = 1; dec_qidx = VEC[i].q;
            dec_s1_en = VEC[i].a_en; dec_s1_reg = VEC[i].a_r;
            dec_s2_en = VEC[i].b_en; dec_s2_reg = VEC[i].b_r;
            dec_d_en = VEC[i].d_en; dec_d_reg = VEC[i].d_r;
            #2;
            chk("R2 vec a arf", s1_use_arf, VEC[i].xa_arf);
            chk("R2 vec a link", s1_link, VEC[i].xa_lk);
            if (VEC[i].xa_lk) begin
                chk("R3 vec a idx", s1_link_idx, VEC[i].xa_i);
                chk("R4 vec a slot", s1_link_slot, VEC[i].xa_s);
            end
            chk("R2 vec b arf", s2_use_arf, VEC[i].xb_arf);
            chk("R2 vec b link", s2_link, VEC[i].xb_lk);
            if (VEC[i].xb_lk) begin
                chk("R3 vec b idx", s2_link_idx, VEC[i].xb_i);
                chk("R3 vec b slot", s2_link_slot, VEC[i].xb_s);
            end
            @(negedge clk);
        end
        // state: r0=8/0 r1=7/1 r2=7/0 r3=8/1 r4=5/0 r5=5/1 r6,r7 null
        probe(1, 0, 1, 7, 1, "R3 final r1");
        probe(2, 0, 1, 7, 0, "R3 final r2");

        // R6: matching commit nulls, stale commit leaves entry
        idle(); cmt_valid = 1; cmt_reg = 3'd4; cmt_qidx = 5'd5; @(negedge clk);
        probe(4, 1, 0, 0, 0, "R6 match");
        idle(); cmt_valid = 1; cmt_reg = 3'd5; cmt_qidx = 5'd4; @(negedge clk);
        probe(5, 0, 1, 5, 1, "R6 stale");

        // R7: decode beats commit on the same register
        idle(); dec_valid = 1; dec_qidx = 5'd13; dec_d_en = 1; dec_d_reg = 3'd5;
        cmt_valid = 1; cmt_reg = 3'd5; cmt_qidx = 5'd5; @(negedge clk);
        probe(5, 0, 1, 13, 2, "R7 decode wins");

        // R5: branch snapshot includes its own update
        idle(); dec_valid = 1; dec_branch = 1; dec_qidx = 5'd9;
        dec_s1_en = 1; dec_s1_reg = 3'd6;
        #2;
        chk("R5 first id", dec_ckpt_id, 0);
        chk("R5 first stall", dec_stall, 0);
        chk("R2 branch src arf", s1_use_arf, 1);
        @(negedge clk);
        idle(); dec_valid = 1; dec_qidx = 5'd10; dec_d_en = 1; dec_d_reg = 3'd6;
        @(negedge clk);
        probe(6, 0, 1, 10, 2, "R4 wrong path");
        branch(11, 1, "R5 second");

        // R8: full stalls
        idle(); dec_valid = 1; dec_branch = 1; dec_qidx = 5'd12;
        #2;
        chk("R8 full stall", dec_stall, 1);
        @(negedge clk);

        // R9: restore slot 0, frees slot 0 and 1
        idle(); br_bad_valid = 1; br_bad_id = 1'b0;
        dec_valid = 1; dec_qidx = 5'd16; dec_d_en = 1; dec_d_reg = 3'd6;
        #2;
        chk("R9 restore stall", dec_stall, 1);
        @(negedge clk);
        probe(6, 0, 1, 9, 0, "R9 restored");
        probe(5, 0, 1, 13, 2, "R9 kept older");
        branch(14, 0, "R9 slot0 freed");
        branch(15, 1, "R9 younger freed");

        // R11: correct predictions release
        idle(); br_ok_valid = 1; br_ok_id = 1'b0; @(negedge clk);
        idle(); br_ok_valid = 1; br_ok_id = 1'b1; @(negedge clk);
        idle(); dec_valid = 1; dec_branch = 1; dec_qidx = 5'd20;
        dec_s1_en = 1; dec_s1_reg = 3'd7;
        #2;
        chk("R11 reuse id", dec_ckpt_id, 0);
        chk("R11 not full", dec_stall, 0);
        @(negedge clk);

        // R10: commit clears inside the held snapshot
        idle(); cmt_valid = 1; cmt_reg = 3'd7; cmt_qidx = 5'd20; @(negedge clk);
        probe(7, 1, 0, 0, 0, "R6 live clear");
        idle(); dec_valid = 1; dec_qidx = 5'd21; dec_s1_en = 1; dec_s1_reg = 3'd7;
        @(negedge clk);
        probe(7, 0, 1, 21, 0, "R3 after clear");
        idle(); br_bad_valid = 1; br_bad_id = 1'b0; @(negedge clk);
        probe(7, 1, 0, 0, 0, "R10 snapshot clear");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule